// File: doc/BRIEF.md
# Stored-Program Processor Core

This block is a small processor that keeps its program and its operands in one word-addressed memory of 256 sixteen-bit words. After reset it repeats a fixed three-step sequence. First it fetches the word that the program counter points to into an instruction register and advances the counter. It then classifies that word, and finally carries out the operation. The sequence stops when a HALT is executed. Four general registers feed a wrap-around adder. The instruction set has four operations: copy a memory word into a register, add two registers into a third, copy a register into memory, and stop.

Memory is filled through a preload port while reset is held. When the core halts, a sticky status output goes high and the memory can be read back through a combinational read port. Because instructions and data share one space, a program can read its own instruction words as data and can overwrite instructions it has not yet reached.

Top module: `stored_prog_core`

## Requirements
- R1: While `rst` is high, `halted` is 0; on release the program counter is 0, so the first fetched word is memory location 0, and all four registers hold 0.
- R2: Every instruction, including the final HALT, takes exactly three clock cycles (fetch, decode, execute). A program that executes N instructions, counting the HALT, raises `halted` on the 3N-th rising edge after `rst` falls.
- R3: Instruction layout: bits [15:12] opcode (0 HALT, 1 LOAD, 2 ADD, 3 STORE); bits [11:10] destination register (or source register for STORE); bits [9:8] first addend register; bits [7:6] second addend register; bits [7:0] memory address for LOAD and STORE.
- R4: LOAD copies the memory word at the address field into the destination register. The word may be an instruction word.
- R5: ADD writes the sum of the two addend registers into the destination register, modulo 2^16, with no carry kept (0xFFFF + 0x0002 gives 0x0001).
- R6: STORE writes the source register into the addressed memory word. A store into a location not yet fetched changes the instruction that is later executed there.
- R7: HALT, and every opcode from 4 to 15, stops execution. `halted` then stays 1, and memory does not change until the next reset.
- R8: `tb_we` writes `tb_wdata` to `tb_addr` only while `rst` is high and is ignored otherwise. `tb_rdata` always shows the word at `tb_addr`.
- R9: The program LOAD R0,5; LOAD R1,6; ADD R2,R0,R1; STORE 7,R2; HALT, with M[5]=9 and M[6]=1, leaves 10 in M[7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables preload |
| tb_we | input | 1 | Preload write enable, effective only during reset |
| tb_addr | input | 8 | Preload / read-back address |
| tb_wdata | input | 16 | Preload data |
| tb_rdata | output | 16 | Memory word at `tb_addr` |
| halted | output | 1 | High once a stopping instruction has executed |

## Verification
A wrong program counter or a wrong sequencer state shows up at `halted`. It rises on the wrong cycle, often many cycles off, or it never rises, which the cycle count against 3N catches at once. A corrupted register, a wrongly decoded field or a misplaced store only shows up in memory after halt. The bench therefore compares all 256 words against a bench-side instruction-level model. Random programs make each STORE expose the results of the LOADs and ADDs before it. Directed programs cover adder wrap-around, undefined opcodes and self-modifying code.

// File: rtl/stored_prog_core.sv
module stored_prog_core #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tb_we,
  input  logic [AW-1:0] tb_addr,
  input  logic [DW-1:0] tb_wdata,
  output logic [DW-1:0] tb_rdata,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam int RW    = $clog2(NREG);
  localparam int OPB   = DW - 4;

  typedef enum logic [1:0] {S_FETCH, S_DECODE, S_EXEC, S_STOP} state_t;
  typedef enum logic [1:0] {K_STOP, K_LOAD, K_ADD, K_STORE} kind_t;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] regs [NREG];
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  state_t        st;
  kind_t         kind;

  wire [3:0]    op   = ir[DW-1 -: 4];
  wire [RW-1:0] rd   = ir[OPB-1 -: RW];
  wire [RW-1:0] ra   = ir[OPB-1-RW -: RW];
  wire [RW-1:0] rb   = ir[OPB-1-2*RW -: RW];
  wire [AW-1:0] addr = ir[AW-1:0];
  wire          mem_we = (st == S_EXEC) && (kind == K_STORE);

  assign tb_rdata = mem[tb_addr];
  assign halted   = (st == S_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_FETCH;
      pc   <= '0;
      ir   <= '0;
      kind <= K_STOP;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem[pc];
          pc <= pc + 1'b1;
          st <= S_DECODE;
        end
        S_DECODE: begin
          case (op)
            4'd1:    kind <= K_LOAD;
            4'd2:    kind <= K_ADD;
            4'd3:    kind <= K_STORE;
            default: kind <= K_STOP;
          endcase
          st <= S_EXEC;
        end
        S_EXEC: begin
          case (kind)
            K_LOAD:  regs[rd] <= mem[addr];
            K_ADD:   regs[rd] <= regs[ra] + regs[rb];
            default: ;
          endcase
          st <= (kind == K_STOP) ? S_STOP : S_FETCH;
        end
        default: st <= S_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (tb_we) mem[tb_addr] <= tb_wdata;
    end else if (mem_we) begin
      mem[addr] <= regs[rd];
    end
  end

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));
  assert_halt_after_exec_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(st) == S_EXEC);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> pc == $past(pc) + 1'b1);
  assert_ir_held_R2: assert property (@(posedge clk) disable iff (rst)
    (st != S_FETCH) |=> $stable(ir));
  assert_no_store_halted_R7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
endmodule

// File: tb/tb_stored_prog_core.sv
module tb_stored_prog_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = '0;
  logic [15:0] tb_wdata = '0;
  logic [15:0] tb_rdata;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [15:0] img [256];
  logic [15:0] ref_mem [256];
  logic [15:0] ref_reg [4];

  stored_prog_core dut (
    .clk(clk), .rst(rst), .tb_we(tb_we), .tb_addr(tb_addr),
    .tb_wdata(tb_wdata), .tb_rdata(tb_rdata), .halted(halted)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int r1, input int r2,
                                      input int r3, input int a);
    return (16'(op) << 12) | (16'(r1) << 10) | (16'(r2) << 8) | (16'(r3) << 6) | 16'(a);
  endfunction

  function automatic int run_model();
    int pc = 0, n = 0;
    logic [15:0] ir;
    for (int i = 0; i < 256; i++) ref_mem[i] = img[i];
    for (int i = 0; i < 4; i++) ref_reg[i] = '0;
    while (n < 1000) begin
      ir = ref_mem[pc];
      pc = (pc + 1) % 256;
      n++;
      case (ir[15:12])
        4'd1: ref_reg[ir[11:10]] = ref_mem[ir[7:0]];
        4'd2: ref_reg[ir[11:10]] = ref_reg[ir[9:8]] + ref_reg[ir[7:6]];
        4'd3: ref_mem[ir[7:0]] = ref_reg[ir[11:10]];
        default: return n;
      endcase
    end
    return n;
  endfunction

  task automatic run_prog(input string tag);
    int n, k;
    n = run_model();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      tb_we = 1'b1; tb_addr = 8'(i); tb_wdata = img[i];
      @(negedge clk);
    end
    tb_we = 1'b0;
    chk(halted == 1'b0, "R1 halted low in reset", halted, 0);
    rst = 1'b0;
    k = 0;
    while (!halted && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk(k == 3 * n, {"R2 halt cycle ", tag}, k, 3 * n);
    for (int i = 0; i < 256; i++) begin
      tb_addr = 8'(i);
      #1;
      chk(tb_rdata == ref_mem[i], {tag, " mem word"}, tb_rdata, ref_mem[i]);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R9 / R1 worked example; R3 encodings
    clear_img();
    img[0] = enc(1, 0, 0, 0, 5);
    img[1] = enc(1, 1, 0, 0, 6);
    img[2] = enc(2, 2, 0, 1, 0);
    img[3] = enc(3, 2, 0, 0, 7);
    img[4] = 16'h0000;
    img[5] = 16'd9; img[6] = 16'd1;
    run_prog("R9 R3 example");
    tb_addr = 8'd7; #1;
    chk(tb_rdata == 16'd10, "R9 sum", tb_rdata, 10);

    // R7 halted stays set and memory held
    repeat (30) @(negedge clk);
    chk(halted == 1'b1, "R7 halted sticky", halted, 1);
    tb_addr = 8'd7; #1;
    chk(tb_rdata == 16'd10, "R7 memory held", tb_rdata, 10);

    // R8 preload port ignored outside reset
    tb_we = 1'b1; tb_addr = 8'd7; tb_wdata = 16'hDEAD;
    repeat (4) @(negedge clk);
    tb_we = 1'b0; #1;
    chk(tb_rdata == 16'd10, "R8 write ignored", tb_rdata, 10);

    // R5 wrap-around
    clear_img();
    img[0] = enc(1, 3, 0, 0, 200);
    img[1] = enc(1, 1, 0, 0, 201);
    img[2] = enc(2, 2, 3, 1, 0);
    img[3] = enc(3, 2, 0, 0, 202);
    img[200] = 16'hFFFF; img[201] = 16'h0002;
    run_prog("R5 wrap");
    tb_addr = 8'd202; #1;
    chk(tb_rdata == 16'h0001, "R5 wrapped sum", tb_rdata, 1);

    // R7 undefined opcode stops execution
    clear_img();
    img[0] = enc(1, 0, 0, 0, 128);
    img[1] = 16'hA5C3;
    img[2] = enc(3, 0, 0, 0, 129);
    img[128] = 16'h4321;
    run_prog("R7 undefined opcode");
    tb_addr = 8'd129; #1;
    chk(tb_rdata == 16'h0000, "R7 no store after undefined op", tb_rdata, 0);

    // R6 self-modifying program; R4 loads an instruction word
    clear_img();
    img[0] = enc(1, 1, 0, 0, 130);
    img[1] = enc(1, 0, 0, 0, 129);
    img[2] = enc(3, 1, 0, 0, 3);
    img[3] = 16'h0000;
    img[4] = 16'h0000;
    img[129] = 16'h1234;
    img[130] = enc(3, 0, 0, 0, 131);
    run_prog("R6 self-modify");
    tb_addr = 8'd131; #1;
    chk(tb_rdata == 16'h1234, "R6 patched instruction ran", tb_rdata, 16'h1234);

    // R4 R5 R6 random programs
    for (int t = 0; t < 12; t++) begin
      int len;
      clear_img();
      len = 3 + int'($urandom % 30);
      for (int i = 0; i < len; i++) begin
        int op = 1 + int'($urandom % 3);
        int a  = (op == 3) ? 128 + int'($urandom % 128) : int'($urandom % 256);
        if (op == 2)
          img[i] = enc(2, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 0);
        else
          img[i] = enc(op, int'($urandom % 4), 0, 0, a);
      end
      for (int i = 128; i < 256; i++) img[i] = 16'($urandom);
      run_prog("R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule